// File: doc/BRIEF.md
# MAC Address Forwarding Table

This block is the forwarding table of a small Ethernet switch. It holds a table of entries. Each entry is free, an address entry, a VLAN entry, or a VLAN entry that also carries an address. A lookup port takes a destination MAC address and the port the frame arrived on, and returns the set of ports the frame should leave by. The lookup scans the table one entry per clock, starting at index 0. The first address entry whose 48-bit MAC matches exactly decides the result. A lookup that matches nothing floods the frame.

Software reaches the table through a small word-addressed register window. There is a global control word, a table-index register that loads or stores one entry, three data words that hold the entry being moved, and one control word per port. Unicast and multicast entries put different meanings on the same upper bits. A unicast entry holds a port number and a blocked flag. A multicast entry holds a port mask. Every result is then gated by a four-state per-port setting, so only ports in the forwarding state ever appear in a result. A global clear empties the table one entry per clock, and lookups are held off while it runs.

Top module: `mac_fwd_table`

## Requirements
- R1: After reset, lk_ready, lk_done and lk_mask are 0. The control word (address 0) and every port control word read 0.
- R2: Address 2 holds data word 0, which is entry bits ENTRY_W-1:64 and reads back zero-extended. Address 3 holds bits 63:32 and address 4 holds bits 31:0. Writing an index to address 1 with bit 31 set stores the three data words into that entry. Writing an index with bit 31 clear loads that entry into the data words. The loaded values can be read two cycles after the write.
- R3: In the control word, bit 31 enables the engine, bit 30 starts a table clear and bit 2 selects VLAN-aware mode. lk_ready is 1 only while the engine is enabled, no lookup is in progress and no clear is running.
- R4: Setting bit 30 writes every entry to all zeros (type free), one entry per clock from index 0. Bit 30 reads 1 and lk_ready stays 0 for exactly DEPTH cycles, after which bit 30 returns to 0 by itself.
- R5: An entry matches when its type (bits 61:60) is 1, or is 3 with VLAN-aware mode off, and its bits 47:0 equal the lookup MAC. The scan starts at index 0 and the lowest matching index wins. For a hit at index k, lk_done pulses k+2 cycles after the request is accepted. For a miss, it pulses DEPTH+1 cycles after acceptance.
- R6: A hit whose bit 40 is 0 is a unicast hit. It returns a one-hot mask for the port number in bits 67:66. It returns an empty mask if the blocked bit 65 is set. The secure bit 64 and the unicast type in bits 63:62 have no effect on the result.
- R7: A hit whose bit 40 is 1 is a multicast hit. It returns the port mask held in bits 66+NUM_PORTS-1:66.
- R8: A miss returns every port in the forwarding state except the ingress port.
- R9: Port p's control word is at address 8+p. Its bits 1:0 hold the port state: 0 disabled, 1 blocking, 2 learning, 3 forwarding. Every result is masked to the ports in state 3. A lookup from an ingress port that is not in state 3 returns an empty mask.
- R10: A table load uses the shared read port. If it falls in a scan cycle, the scan waits one cycle. The lookup result is still correct and arrives one cycle later.
- R11: A table store issued while a clear is running is discarded.
- R12: With VLAN-aware mode on, type-3 entries are skipped by the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for cfg_addr |
| lk_valid | input | 1 | Lookup request, held until accepted |
| lk_mac | input | 48 | Destination MAC to look up |
| lk_port | input | PNUM_W | Ingress port of the frame |
| lk_ready | output | 1 | Lookup is accepted on this edge if lk_valid is high |
| lk_done | output | 1 | One-cycle pulse: lk_mask carries a new result |
| lk_mask | output | NUM_PORTS | Egress port set |

## Verification
Two functions can meet in one cycle. A software table load and the scan of a lookup both want the single read port of the table. The bench provokes this by writing a load to the table-index register one cycle after a lookup is accepted. It then checks that the hit arrives exactly one cycle later than its undisturbed latency and still carries the right ports, and that the data words hold the loaded entry. A second collision is a lookup request raised while a clear runs. It is judged by counting the cycles that lk_ready stays low against DEPTH.

// File: rtl/mft_pkg.sv
`timescale 1ns/1ps
package mft_pkg;
  typedef enum logic [1:0] {
    ET_FREE      = 2'd0,
    ET_ADDR      = 2'd1,
    ET_VLAN      = 2'd2,
    ET_VLAN_ADDR = 2'd3
  } ent_type_e;

  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_BLOCK = 2'd1,
    PS_LEARN = 2'd2,
    PS_FWD   = 2'd3
  } port_state_e;

  // entry field positions
  localparam int TYPE_LO    = 60;
  localparam int MCAST_BIT  = 40;
  localparam int SECURE_BIT = 64;
  localparam int BLOCK_BIT  = 65;
  localparam int PORT_LO    = 66;

  // control and table-index bits
  localparam int CTRL_EN   = 31;
  localparam int CTRL_CLR  = 30;
  localparam int CTRL_VLAN = 2;
  localparam int TBL_WR    = 31;

  // register word addresses
  localparam int RA_CTRL  = 0;
  localparam int RA_TBL   = 1;
  localparam int RA_DW0   = 2;
  localparam int RA_DW1   = 3;
  localparam int RA_DW2   = 4;
  localparam int RA_PORT0 = 8;
endpackage

// File: rtl/mft_ram.sv
`timescale 1ns/1ps
module mft_ram #(
  parameter int W     = 69,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);
  logic [W-1:0] mem [DEPTH];

  // one write port, one registered read port (read-first)
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/mft_regs.sv
`timescale 1ns/1ps
module mft_regs
  import mft_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int DEPTH     = 16,
  parameter int IDX_W     = 4,
  parameter int ENTRY_W   = 69,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic [ENTRY_W-1:0]   ram_q,
  output logic                 en,
  output logic                 vlan_aware,
  output logic                 clearing,
  output logic [IDX_W-1:0]     clr_idx,
  output logic                 sw_ld,
  output logic                 sw_st,
  output logic [IDX_W-1:0]     sw_idx,
  output logic [ENTRY_W-1:0]   sw_entry,
  output logic [NUM_PORTS-1:0] fwd_mask
);
  localparam int W0 = ENTRY_W - 64;

  logic [W0-1:0]    dw0;
  logic [31:0]      dw1, dw2;
  logic [IDX_W-1:0] tbl_idx;
  logic             ld_q;
  logic [1:0]       port_st [NUM_PORTS];
  logic [31:0]      rd_next;

  logic wr_ctrl, wr_tbl;
  assign wr_ctrl = cfg_we && (cfg_addr == ADDR_W'(RA_CTRL));
  assign wr_tbl  = cfg_we && (cfg_addr == ADDR_W'(RA_TBL));

  assign sw_idx   = cfg_wdata[IDX_W-1:0];
  assign sw_ld    = wr_tbl && !cfg_wdata[TBL_WR];
  assign sw_st    = wr_tbl && cfg_wdata[TBL_WR] && !clearing;
  assign sw_entry = {dw0, dw1, dw2};

  // global control and self-clearing table wipe
  always_ff @(posedge clk) begin
    if (rst) begin
      en         <= 1'b0;
      vlan_aware <= 1'b0;
      clearing   <= 1'b0;
      clr_idx    <= '0;
    end else begin
      if (wr_ctrl) begin
        en         <= cfg_wdata[CTRL_EN];
        vlan_aware <= cfg_wdata[CTRL_VLAN];
        if (cfg_wdata[CTRL_CLR] && !clearing) begin
          clearing <= 1'b1;
          clr_idx  <= '0;
        end
      end
      if (clearing) begin
        clr_idx <= clr_idx + 1'b1;
        if (clr_idx == IDX_W'(DEPTH - 1)) clearing <= 1'b0;
      end
    end
  end

  // data words and table index
  always_ff @(posedge clk) begin
    if (rst) begin
      dw0     <= '0;
      dw1     <= '0;
      dw2     <= '0;
      tbl_idx <= '0;
      ld_q    <= 1'b0;
    end else begin
      ld_q <= sw_ld;
      if (wr_tbl) tbl_idx <= cfg_wdata[IDX_W-1:0];
      if (ld_q) begin
        dw0 <= ram_q[ENTRY_W-1:64];
        dw1 <= ram_q[63:32];
        dw2 <= ram_q[31:0];
      end else if (cfg_we) begin
        if (cfg_addr == ADDR_W'(RA_DW0)) dw0 <= cfg_wdata[W0-1:0];
        if (cfg_addr == ADDR_W'(RA_DW1)) dw1 <= cfg_wdata;
        if (cfg_addr == ADDR_W'(RA_DW2)) dw2 <= cfg_wdata;
      end
    end
  end

  // per-port state words
  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (rst) port_st[p] <= PS_OFF;
      else if (cfg_we && cfg_addr == ADDR_W'(RA_PORT0 + p)) port_st[p] <= cfg_wdata[1:0];
    end
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_fwd
    assign fwd_mask[g] = (port_st[g] == PS_FWD);
  end

  always_comb begin
    rd_next = '0;
    if (cfg_addr == ADDR_W'(RA_CTRL)) begin
      rd_next[CTRL_EN]   = en;
      rd_next[CTRL_CLR]  = clearing;
      rd_next[CTRL_VLAN] = vlan_aware;
    end else if (cfg_addr == ADDR_W'(RA_TBL)) begin
      rd_next[IDX_W-1:0] = tbl_idx;
    end else if (cfg_addr == ADDR_W'(RA_DW0)) begin
      rd_next[W0-1:0] = dw0;
    end else if (cfg_addr == ADDR_W'(RA_DW1)) begin
      rd_next = dw1;
    end else if (cfg_addr == ADDR_W'(RA_DW2)) begin
      rd_next = dw2;
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (cfg_addr == ADDR_W'(RA_PORT0 + p)) rd_next[1:0] = port_st[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_next;
  end

  // a wipe always ends right after the last index has been written
  assert_clear_len_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(clearing) |-> $past(clr_idx) == IDX_W'(DEPTH - 1));

  // a load captures exactly what the table returned
  assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
    ld_q |=> sw_entry == $past(ram_q));
endmodule

// File: rtl/mft_search.sv
`timescale 1ns/1ps
module mft_search
  import mft_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int DEPTH     = 16,
  parameter int IDX_W     = 4,
  parameter int ENTRY_W   = 69,
  parameter int PNUM_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lk_valid,
  input  logic [47:0]          lk_mac,
  input  logic [PNUM_W-1:0]    lk_port,
  input  logic                 en,
  input  logic                 clearing,
  input  logic                 hold,
  input  logic                 vlan_aware,
  input  logic [NUM_PORTS-1:0] fwd_mask,
  input  logic [ENTRY_W-1:0]   ram_q,
  output logic [IDX_W-1:0]     scan_addr,
  output logic                 lk_ready,
  output logic                 lk_done,
  output logic [NUM_PORTS-1:0] lk_mask
);
  logic              busy, issued_all, vld, last_r;
  logic [IDX_W-1:0]  issue_idx;
  logic [47:0]       mac_r;
  logic [PNUM_W-1:0] port_r;

  logic                 issue, is_addr, hit, ing_ok;
  logic [1:0]           etype;
  logic [NUM_PORTS-1:0] ing_oh, uc_oh, mc_mask, hit_mask, flood, res;
  logic                 unused_fields;

  assign lk_ready  = !busy && en && !clearing;
  assign issue     = busy && !hold && !issued_all;
  assign scan_addr = issue_idx;

  assign etype   = ram_q[TYPE_LO+1:TYPE_LO];
  assign is_addr = (etype == ET_ADDR) || (etype == ET_VLAN_ADDR && !vlan_aware);
  assign hit     = vld && busy && is_addr && (ram_q[47:0] == mac_r);
  assign mc_mask = ram_q[PORT_LO +: NUM_PORTS];
  assign unused_fields = ^{ram_q[SECURE_BIT], ram_q[63:62], ram_q[59:48]};

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      ing_oh[i] = (port_r == PNUM_W'(i));
      uc_oh[i]  = (ram_q[PORT_LO +: PNUM_W] == PNUM_W'(i));
    end
    ing_ok   = |(ing_oh & fwd_mask);
    hit_mask = ram_q[MCAST_BIT] ? mc_mask : (ram_q[BLOCK_BIT] ? '0 : uc_oh);
    flood    = fwd_mask & ~ing_oh;
    res      = ing_ok ? ((hit ? hit_mask : flood) & fwd_mask) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      issued_all <= 1'b0;
      vld        <= 1'b0;
      last_r     <= 1'b0;
      issue_idx  <= '0;
      mac_r      <= '0;
      port_r     <= '0;
      lk_done    <= 1'b0;
      lk_mask    <= '0;
    end else begin
      lk_done <= 1'b0;
      vld     <= issue;
      if (issue) begin
        last_r    <= (issue_idx == IDX_W'(DEPTH - 1));
        issue_idx <= issue_idx + 1'b1;
        if (issue_idx == IDX_W'(DEPTH - 1)) issued_all <= 1'b1;
      end
      if (!busy && lk_valid && lk_ready) begin
        busy       <= 1'b1;
        issue_idx  <= '0;
        issued_all <= 1'b0;
        mac_r      <= lk_mac;
        port_r     <= lk_port;
      end else if (busy && vld && (hit || last_r)) begin
        busy    <= 1'b0;
        lk_done <= 1'b1;
        lk_mask <= res;
      end
    end
  end

  assert_mask_fwd_R9: assert property (@(posedge clk) disable iff (rst)
    lk_done |-> (lk_mask & ~$past(fwd_mask)) == '0);

  assert_ingress_gate_R9: assert property (@(posedge clk) disable iff (rst)
    lk_done && !$past(ing_ok) |-> lk_mask == '0);

  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (rst)
    busy && hold |=> $stable(issue_idx));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    lk_done |=> !lk_done);
endmodule

// File: rtl/mac_fwd_table.sv
`timescale 1ns/1ps
module mac_fwd_table #(
  parameter int NUM_PORTS = 3,
  parameter int DEPTH     = 16,
  parameter int ADDR_W    = 5,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ENTRY_W  = 66 + NUM_PORTS,
  localparam int PNUM_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic                 lk_valid,
  input  logic [47:0]          lk_mac,
  input  logic [PNUM_W-1:0]    lk_port,
  output logic                 lk_ready,
  output logic                 lk_done,
  output logic [NUM_PORTS-1:0] lk_mask
);
  logic                 en, vlan_aware, clearing, sw_ld, sw_st;
  logic [IDX_W-1:0]     clr_idx, sw_idx, scan_addr;
  logic [ENTRY_W-1:0]   sw_entry, ram_q;
  logic [NUM_PORTS-1:0] fwd_mask;

  logic                 ram_we;
  logic [IDX_W-1:0]     ram_waddr, ram_raddr;
  logic [ENTRY_W-1:0]   ram_wdata;

  // the wipe owns the write port; a software load owns the read port
  assign ram_we    = clearing || sw_st;
  assign ram_waddr = clearing ? clr_idx : sw_idx;
  assign ram_wdata = clearing ? '0 : sw_entry;
  assign ram_raddr = sw_ld ? sw_idx : scan_addr;

  mft_regs #(
    .NUM_PORTS(NUM_PORTS), .DEPTH(DEPTH), .IDX_W(IDX_W),
    .ENTRY_W(ENTRY_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ram_q(ram_q),
    .en(en), .vlan_aware(vlan_aware), .clearing(clearing), .clr_idx(clr_idx),
    .sw_ld(sw_ld), .sw_st(sw_st), .sw_idx(sw_idx), .sw_entry(sw_entry),
    .fwd_mask(fwd_mask)
  );

  mft_ram #(.W(ENTRY_W), .DEPTH(DEPTH), .AW(IDX_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .q(ram_q)
  );

  mft_search #(
    .NUM_PORTS(NUM_PORTS), .DEPTH(DEPTH), .IDX_W(IDX_W),
    .ENTRY_W(ENTRY_W), .PNUM_W(PNUM_W)
  ) u_search (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_mac(lk_mac),
    .lk_port(lk_port), .en(en), .clearing(clearing), .hold(sw_ld),
    .vlan_aware(vlan_aware), .fwd_mask(fwd_mask), .ram_q(ram_q),
    .scan_addr(scan_addr), .lk_ready(lk_ready), .lk_done(lk_done),
    .lk_mask(lk_mask)
  );
endmodule

// File: tb/mac_fwd_table_bench.sv
`timescale 1ns/1ps
module mac_fwd_table_bench;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_mac = '0;
  logic [1:0]  lk_port = '0;
  logic        lk_ready, lk_done;
  logic [2:0]  lk_mask;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  mac_fwd_table u_mac_fwd_table (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
    .lk_mac(lk_mac), .lk_port(lk_port), .lk_ready(lk_ready),
    .lk_done(lk_done), .lk_mask(lk_mask)
  );

  localparam logic [47:0] MAC_A = 48'h02_11_22_33_44_55;
  localparam logic [47:0] MAC_B = 48'h02_11_22_33_44_66;
  localparam logic [47:0] MAC_C = 48'h02_11_22_33_44_77;
  localparam logic [47:0] MAC_V = 48'h02_11_22_33_44_88;
  localparam logic [47:0] MAC_M = 48'h01_00_5e_00_00_07;
  localparam logic [47:0] MAC_X = 48'h02_aa_bb_cc_dd_ee;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [4:0] a, output logic [31:0] d);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  function automatic logic [68:0] ent_uc(input logic [47:0] mac, input logic [1:0] p,
                                          input logic blk, input logic sec);
    logic [68:0] e = '0;
    e[61:60] = 2'd1; e[47:0] = mac; e[64] = sec; e[65] = blk; e[67:66] = p;
    e[63:62] = 2'd3;
    return e;
  endfunction

  function automatic logic [68:0] ent_mc(input logic [47:0] mac, input logic [2:0] m);
    logic [68:0] e = '0;
    e[61:60] = 2'd1; e[63:62] = 2'd3; e[47:0] = mac; e[68:66] = m;
    return e;
  endfunction

  function automatic logic [68:0] ent_va(input logic [47:0] mac, input logic [1:0] p);
    logic [68:0] e = '0;
    e[61:60] = 2'd3; e[47:0] = mac; e[67:66] = p;
    return e;
  endfunction

  task automatic put_entry(input int idx, input logic [68:0] e);
    cfg_write(5'd2, {27'd0, e[68:64]});
    cfg_write(5'd3, e[63:32]);
    cfg_write(5'd4, e[31:0]);
    cfg_write(5'd1, 32'h8000_0000 | idx);
  endtask

  task automatic get_entry(input int idx, output logic [68:0] e);
    logic [31:0] w0, w1, w2;
    cfg_write(5'd1, idx);
    @(negedge clk);
    cfg_read(5'd2, w0);
    cfg_read(5'd3, w1);
    cfg_read(5'd4, w2);
    e = {w0[4:0], w1, w2};
  endtask

  task automatic lookup(input logic [47:0] mac, input logic [1:0] p,
                        output logic [2:0] m, output int n);
    lk_valid = 1'b1; lk_mac = mac; lk_port = p;
    while (!lk_ready) @(negedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    n = 0;
    while (!lk_done && n < 1000) begin
      @(negedge clk);
      n++;
    end
    m = lk_mask;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 lk_ready", lk_ready, 0);
    chk("R1 lk_done", lk_done, 0);
    chk("R1 lk_mask", lk_mask, 0);
    cfg_read(5'd0, d); chk("R1 control", d, 0);
    cfg_read(5'd9, d); chk("R1 port1", d, 0);
  endtask

  task automatic t_window;
    logic [31:0] d;
    logic [68:0] e;
    cfg_write(5'd2, 32'hffff_ffff);
    cfg_read(5'd2, d); chk("R2 word0 width", d, 32'h1f);
    cfg_write(5'd3, 32'hcafe_f00d);
    cfg_read(5'd3, d); chk("R2 word1", d, 32'hcafe_f00d);
    put_entry(9, {5'h15, 32'hdead_beef, 32'h1234_5678});
    cfg_write(5'd2, 0); cfg_write(5'd3, 0); cfg_write(5'd4, 0);
    get_entry(9, e);
    chk("R2 load", e, {5'h15, 32'hdead_beef, 32'h1234_5678});
  endtask

  task automatic t_clear;
    logic [31:0] d;
    logic [68:0] e;
    int c;
    cfg_write(5'd0, 32'hc000_0000);
    c = 0;
    while (!lk_ready && c < 100) begin
      c++;
      @(negedge clk);
    end
    chk("R4 clear cycles", c, DEPTH);
    chk("R3 ready when enabled", lk_ready, 1);
    get_entry(9, e);
    chk("R4 entry zeroed", e, 0);
    cfg_write(5'd0, 32'hc000_0000);
    cfg_read(5'd0, d); chk("R4 clear bit busy", d, 32'hc000_0000);
    repeat (DEPTH) @(negedge clk);
    cfg_read(5'd0, d); chk("R4 clear bit self-clears", d, 32'h8000_0000);
  endtask

  task automatic t_store_in_clear;
    logic [68:0] e;
    cfg_write(5'd2, 32'h7); cfg_write(5'd3, 32'h5555_5555); cfg_write(5'd4, 32'haaaa_aaaa);
    cfg_write(5'd0, 32'hc000_0000);
    @(negedge clk);
    cfg_write(5'd1, 32'h8000_0000);
    while (!lk_ready) @(negedge clk);
    get_entry(0, e);
    chk("R11 store during clear dropped", e, 0);
  endtask

  task automatic t_fill;
    logic [31:0] d;
    for (int p = 0; p < 3; p++) cfg_write(5'(8 + p), 32'h3);
    cfg_read(5'd9, d); chk("R9 port readback", d, 3);
    put_entry(0, ent_uc(MAC_A, 2'd1, 1'b0, 1'b0));
    put_entry(1, ent_uc(MAC_B, 2'd2, 1'b1, 1'b0));
    put_entry(2, ent_mc(MAC_M, 3'b101));
    put_entry(3, ent_va(MAC_V, 2'd0));
    put_entry(5, ent_uc(MAC_C, 2'd2, 1'b0, 1'b1));
    put_entry(6, ent_uc(MAC_C, 2'd0, 1'b0, 1'b0));
    put_entry(9, {5'h0a, 32'h0bad_cafe, 32'h600d_f00d});
  endtask

  task automatic t_unicast;
    logic [2:0] m; int n;
    lookup(MAC_A, 2'd0, m, n);
    chk("R6 unicast port", m, 3'b010);
    chk("R5 hit latency idx0", n, 2);
    lookup(MAC_B, 2'd0, m, n);
    chk("R6 blocked empty", m, 3'b000);
    lookup(MAC_C, 2'd1, m, n);
    chk("R5 first match, R6 secure ignored", m, 3'b100);
    chk("R5 hit latency idx5", n, 7);
  endtask

  task automatic t_multicast;
    logic [2:0] m; int n;
    lookup(MAC_M, 2'd0, m, n);
    chk("R7 multicast mask", m, 3'b101);
  endtask

  task automatic t_miss;
    logic [2:0] m; int n;
    lookup(MAC_X, 2'd1, m, n);
    chk("R8 flood from port1", m, 3'b101);
    chk("R5 miss latency", n, DEPTH + 1);
  endtask

  task automatic t_vlan;
    logic [2:0] m; int n;
    lookup(MAC_V, 2'd2, m, n);
    chk("R5 type3 match", m, 3'b001);
    cfg_write(5'd0, 32'h8000_0004);
    lookup(MAC_V, 2'd2, m, n);
    chk("R12 type3 skipped", m, 3'b011);
    cfg_write(5'd0, 32'h8000_0000);
  endtask

  task automatic t_port_state;
    logic [2:0] m; int n;
    cfg_write(5'd10, 32'h2);
    lookup(MAC_M, 2'd0, m, n);
    chk("R9 mcast masked", m, 3'b001);
    lookup(MAC_A, 2'd2, m, n);
    chk("R9 ingress not forwarding", m, 3'b000);
    lookup(MAC_X, 2'd0, m, n);
    chk("R9 flood masked", m, 3'b010);
    cfg_write(5'd10, 32'h3);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    int n;
    lk_valid = 1'b1; lk_mac = MAC_C; lk_port = 2'd1;
    while (!lk_ready) @(negedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
    n = 1;
    cfg_we = 1'b1; cfg_addr = 5'd1; cfg_wdata = 32'd9;
    @(negedge clk);
    n = 2;
    cfg_we = 1'b0;
    while (!lk_done && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk("R10 result during load", lk_mask, 3'b100);
    chk("R10 latency plus one", n, 8);
    cfg_read(5'd4, d); chk("R10 load data", d, 32'h600d_f00d);
  endtask

  task automatic t_disable;
    cfg_write(5'd0, 32'h0);
    chk("R3 disabled not ready", lk_ready, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_window;
    t_clear;
    t_store_in_clear;
    t_fill;
    t_unicast;
    t_multicast;
    t_miss;
    t_vlan;
    t_port_state;
    t_collide;
    t_disable;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule